// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Promotion

This block decides which interrupt a CPU services next. It watches a fixed set of maskable sources and one non-maskable request line. Each maskable source has a flag and a local enable. The first maskable source is the external IRQ pin, and a mode input sets that pin to level or falling-edge detection. The block holds the CPU's two mask bits. The global mask (I) gates every maskable source. The non-maskable mask (X) gates only the XIRQ line.

Each edge of the clock may accept one request. On acceptance the block pulses `ack_o` for one cycle and loads `vec_o` with the 16-bit vector of the winner. It also sets the mask bits that keep the same class from interrupting again. A 7-bit promotion register lifts any one maskable source above the default order. Software writes that source's vector low byte into the register, and the write is accepted only while I is set.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A maskable source is accepted only when its flag is 1, its `en_i` bit is 1 and the I mask was 0 before the edge. A clear local enable or a set I blocks it, and `ack_o` stays 0.
- R2: Maskable source k has vector low byte 0xF2 - 2k. Source 0 is IRQ, source 1 the real-time tick, sources 2-9 timer channels 0-7 and source 10 timer overflow. Flag bit p of `flag_i` belongs to source p+1. Without promotion, the lowest-numbered requesting source wins.
- R3: A write with I set stores `prio_wdata_i` (bits [7:1] of a vector low byte). A requesting source whose vector bits [7:1] equal the stored value wins over all other maskable sources, for example 0xDE for source 10.
- R4: After reset the promotion register selects IRQ. A write while I is 0 leaves it unchanged.
- R5: A stored value that matches no source gives the default order of R2.
- R6: With `irq_edge_i`=1, a falling edge on `irq_n_i` latches an IRQ request. The request stays pending after the pin returns high, until IRQ is accepted. Acceptance clears it.
- R7: With `irq_edge_i`=0, IRQ requests while `irq_n_i` is low. It is accepted again each time I is cleared, and it stops requesting once the pin is high.
- R8: XIRQ (`xirq_n_i` low) is gated only by X and outranks every maskable source. Its vector is 0xFFF4. X is 1 after reset and cleared by `x_clr_i`. X is set only by reset or by accepting XIRQ.
- R9: On acceptance, `ack_o` is 1 for exactly the cycle after the deciding edge, and `vec_o` = {0xFF, low byte}. I is set. Accepting XIRQ also sets X.
- R10: Reset gives I=1, X=1 and `ack_o`=0. `i_set_i` sets I. `i_clr_i` clears I unless an acceptance sets it at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flag_i | input | N_SRC-1 | Peripheral flags, bit p for source p+1 |
| en_i | input | N_SRC | Local enables, bit k for source k |
| irq_n_i | input | 1 | External IRQ pin, active low |
| irq_edge_i | input | 1 | IRQ mode: 0 low level, 1 falling edge |
| xirq_n_i | input | 1 | Non-maskable request, active low |
| i_set_i | input | 1 | Set the I mask |
| i_clr_i | input | 1 | Clear the I mask |
| x_clr_i | input | 1 | Clear the X mask |
| prio_wr_i | input | 1 | Promotion register write strobe |
| prio_wdata_i | input | 7 | Vector low byte bits [7:1] to promote |
| ack_o | output | 1 | Acceptance pulse |
| vec_o | output | 16 | Vector of the last accepted request |
| i_mask_o | output | 1 | Current I mask |
| x_mask_o | output | 1 | Current X mask |

## Verification
`ack_o`, `vec_o` and both masks are registered, so each responds at the first rising edge after its inputs change. A request that waits only for `i_clr_i` or `x_clr_i` is accepted one edge later: the decision at that first edge still sees the old mask. The driver changes inputs on falling edges and queues one expected result per cycle. The monitor compares each result 1 ns after the following rising edge. This puts each check exactly one register stage behind its stimulus.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  // vector low byte of maskable source idx, counting down by two from the top
  function automatic logic [7:0] src_vec_lo(input logic [7:0] top, input int unsigned idx);
    return top - 8'(idx << 1);
  endfunction
endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_n_i,
  input  logic edge_mode_i,
  input  logic enable_i,
  input  logic consume_i,
  output logic active_o
);
  logic prev_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= pin_n_i;
      if (!edge_mode_i)                pend_q <= 1'b0;
      else if (prev_q && !pin_n_i)     pend_q <= 1'b1;
      else if (consume_i)              pend_q <= 1'b0;
    end
  end

  assign active_o = enable_i & (edge_mode_i ? pend_q : ~pin_n_i);
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int unsigned    N_SRC   = 16,
  parameter int unsigned    IDX_W   = 4,
  parameter logic [7:0]     VEC_TOP = 8'hF2
) (
  input  logic [N_SRC-1:0] active_i,
  input  logic [6:0]       promo_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  import irq_prio_pkg::*;

  logic [N_SRC-1:0] match;

  for (genvar g = 0; g < N_SRC; g++) begin : g_match
    localparam logic [7:0] VL = src_vec_lo(VEC_TOP, g);
    assign match[g] = (VL[7:1] == promo_i);
  end

  logic [N_SRC-1:0] hit;
  assign hit   = match & active_i;
  assign any_o = |active_i;

  always_comb begin
    idx_o = '0;
    for (int k = N_SRC - 1; k >= 0; k--)
      if (active_i[k]) idx_o = IDX_W'(k);
    if (|hit)
      for (int k = 0; k < N_SRC; k++)
        if (hit[k]) idx_o = IDX_W'(k);
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int unsigned N_SRC    = 16,
  parameter logic [7:0]  VEC_TOP  = 8'hF2,
  parameter logic [7:0]  VEC_XIRQ = 8'hF4,
  parameter logic [7:0]  VEC_HI   = 8'hFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-2:0] flag_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             irq_n_i,
  input  logic             irq_edge_i,
  input  logic             xirq_n_i,
  input  logic             i_set_i,
  input  logic             i_clr_i,
  input  logic             x_clr_i,
  input  logic             prio_wr_i,
  input  logic [7:1]       prio_wdata_i,
  output logic             ack_o,
  output logic [15:0]      vec_o,
  output logic             i_mask_o,
  output logic             x_mask_o
);
  import irq_prio_pkg::*;

  localparam int unsigned IDX_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [6:0]  PROMO_RST = VEC_TOP[7:1];

  logic             i_q, x_q, ack_q;
  logic [6:0]       promo_q;
  logic [15:0]      vec_q;
  logic [N_SRC-1:0] active;
  logic             irq_act, any_m;
  logic [IDX_W-1:0] win_idx;
  logic             take_x, take_m, take;

  irq_pin_detect u_pin (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_n_i    (irq_n_i),
    .edge_mode_i(irq_edge_i),
    .enable_i   (en_i[0]),
    .consume_i  (take_m && (win_idx == '0)),
    .active_o   (irq_act)
  );

  assign active = {flag_i & en_i[N_SRC-1:1], irq_act};

  irq_prio_sel #(.N_SRC(N_SRC), .IDX_W(IDX_W), .VEC_TOP(VEC_TOP)) u_sel (
    .active_i(active),
    .promo_i (promo_q),
    .any_o   (any_m),
    .idx_o   (win_idx)
  );

  assign take_x = ~xirq_n_i & ~x_q;
  assign take_m = any_m & ~i_q & ~take_x;
  assign take   = take_x | take_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_q     <= 1'b1;
      x_q     <= 1'b1;
      ack_q   <= 1'b0;
      vec_q   <= '0;
      promo_q <= PROMO_RST;
    end else begin
      ack_q <= take;
      if (take)
        vec_q <= {VEC_HI, take_x ? VEC_XIRQ : src_vec_lo(VEC_TOP, 32'(win_idx))};
      if (take || i_set_i) i_q <= 1'b1;
      else if (i_clr_i)    i_q <= 1'b0;
      if (take_x)          x_q <= 1'b1;
      else if (x_clr_i)    x_q <= 1'b0;
      // promotion select is write-protected while I is clear
      if (prio_wr_i && i_q) promo_q <= prio_wdata_i;
    end
  end

  assign ack_o    = ack_q;
  assign vec_o    = vec_q;
  assign i_mask_o = i_q;
  assign x_mask_o = x_q;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter logic [7:0] VEC_XIRQ = 8'hF4,
  parameter logic [7:0] VEC_HI   = 8'hFF
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ack_o,
  input logic [15:0] vec_o,
  input logic        i_mask_o,
  input logic        x_mask_o,
  input logic [6:0]  promo
);
  logic ack_x, ack_m;
  assign ack_x = ack_o && (vec_o[7:0] == VEC_XIRQ);
  assign ack_m = ack_o && (vec_o[7:0] != VEC_XIRQ);

  p_ack_sets_i_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> i_mask_o);

  p_xack_sets_x_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_x |-> x_mask_o);

  p_vec_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (vec_o[15:8] == VEC_HI));

  p_single_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_m |=> !ack_m);

  p_xirq_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_x |-> !$past(x_mask_o));

  p_mask_gates_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_m |-> !$past(i_mask_o));

  p_promo_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(i_mask_o) |-> (promo == $past(promo)));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.VEC_XIRQ(VEC_XIRQ), .VEC_HI(VEC_HI)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ack_o   (ack_o),
  .vec_o   (vec_o),
  .i_mask_o(i_mask_o),
  .x_mask_o(x_mask_o),
  .promo   (promo_q)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  localparam int N = 16;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [N-2:0]  flag = '0;
  logic [N-1:0]  en = '0;
  logic          irq_n = 1'b1, irq_edge = 1'b0, xirq_n = 1'b1;
  logic          i_set = 1'b0, i_clr = 1'b0, x_clr = 1'b0, prio_wr = 1'b0;
  logic [7:1]    prio_wdata = '0;
  logic          ack, i_mask, x_mask;
  logic [15:0]   vec;

  always #2 clk = ~clk;

  irq_prio_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .flag_i(flag), .en_i(en), .irq_n_i(irq_n),
    .irq_edge_i(irq_edge), .xirq_n_i(xirq_n), .i_set_i(i_set), .i_clr_i(i_clr),
    .x_clr_i(x_clr), .prio_wr_i(prio_wr), .prio_wdata_i(prio_wdata),
    .ack_o(ack), .vec_o(vec), .i_mask_o(i_mask), .x_mask_o(x_mask)
  );

  typedef struct {
    bit          ack;
    logic [15:0] vec;
    bit          im;
    bit          xm;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic step(input bit a, input logic [15:0] v, input bit im, input bit xm, input string tag);
    exp_t e;
    e.ack = a; e.vec = v; e.im = im; e.xm = xm; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp_v);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  // monitor: one expected item per cycle, sampled 1 ns after the rising edge
  initial forever begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " ack"}, 16'(ack), 16'(e.ack));
      if (e.ack) chk({e.tag, " vec"}, vec, e.vec);
      chk({e.tag, " I"}, 16'(i_mask), 16'(e.im));
      chk({e.tag, " X"}, 16'(x_mask), 16'(e.xm));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step(0, 16'h0, 1, 1, "R10 reset");

    // R1: global and local masking
    en[2] = 1'b1; flag[1] = 1'b1;
    step(0, 16'h0, 1, 1, "R1 held by I");
    i_clr = 1'b1; step(0, 16'h0, 0, 1, "R10 clear I");
    i_clr = 1'b0; step(1, 16'hFFEE, 1, 1, "R1 accepted");
    step(0, 16'h0, 1, 1, "R9 single pulse");
    flag[1] = 1'b0;
    i_clr = 1'b1; step(0, 16'h0, 0, 1, "R10 clear I");
    i_clr = 1'b0; en[2] = 1'b0; flag[1] = 1'b1;
    step(0, 16'h0, 0, 1, "R1 local enable off");
    step(0, 16'h0, 0, 1, "R1 local enable off");
    flag[1] = 1'b0; en[2] = 1'b1;

    // R2: default order
    i_set = 1'b1; step(0, 16'h0, 1, 1, "R10 set I");
    i_set = 1'b0;
    flag[2] = 1'b1; flag[10] = 1'b1; en[3] = 1'b1; en[11] = 1'b1;
    i_clr = 1'b1; step(0, 16'h0, 0, 1, "R10 clear I");
    i_clr = 1'b0; step(1, 16'hFFEC, 1, 1, "R2 lowest wins");
    flag[2] = 1'b0; flag[10] = 1'b0;

    // R3: promote timer overflow (0xDE)
    prio_wr = 1'b1; prio_wdata = 7'h6F; step(0, 16'h0, 1, 1, "R3 write");
    prio_wr = 1'b0;
    flag[9] = 1'b1; en[10] = 1'b1; flag[2] = 1'b1;
    i_clr = 1'b1; step(0, 16'h0, 0, 1, "R10 clear I");
    i_clr = 1'b0; step(1, 16'hFFDE, 1, 1, "R3 promoted wins");
    flag[9] = 1'b0; flag[2] = 1'b0;

    // R4: write with I clear is ignored
    i_clr = 1'b1; step(0, 16'h0, 0, 1, "R10 clear I");
    i_clr = 1'b0;
    prio_wr = 1'b1; prio_wdata = 7'h78; step(0, 16'h0, 0, 1, "R4 blocked write");
    prio_wr = 1'b0;
    i_set = 1'b1; step(0, 16'h0, 1, 1, "R10 set I");
    i_set = 1'b0;
    flag[0] = 1'b1; en[1] = 1'b1; flag[9] = 1'b1;
    i_clr = 1'b1; step(0, 16'h0, 0, 1, "R10 clear I");
    i_clr = 1'b0; step(1, 16'hFFDE, 1, 1, "R4 promotion kept");
    flag[0] = 1'b0; flag[9] = 1'b0;

    // R5: unmatched value restores default order
    prio_wr = 1'b1; prio_wdata = 7'h08; step(0, 16'h0, 1, 1, "R5 write");
    prio_wr = 1'b0;
    flag[0] = 1'b1; flag[9] = 1'b1;
    i_clr = 1'b1; step(0, 16'h0, 0, 1, "R10 clear I");
    i_clr = 1'b0; step(1, 16'hFFF0, 1, 1, "R5 default order");
    flag[0] = 1'b0; flag[9] = 1'b0;

    // R6: edge-detected IRQ latched
    irq_edge = 1'b1; en[0] = 1'b1;
    irq_n = 1'b0; step(0, 16'h0, 1, 1, "R6 edge while masked");
    irq_n = 1'b1; i_clr = 1'b1; step(0, 16'h0, 0, 1, "R10 clear I");
    i_clr = 1'b0; step(1, 16'hFFF2, 1, 1, "R6 pending accepted");
    i_clr = 1'b1; step(0, 16'h0, 0, 1, "R10 clear I");
    i_clr = 1'b0; step(0, 16'h0, 0, 1, "R6 pending cleared");
    step(0, 16'h0, 0, 1, "R6 pending cleared");

    // R7: level-detected IRQ
    irq_edge = 1'b0; step(0, 16'h0, 0, 1, "R7 pin high");
    irq_n = 1'b0; step(1, 16'hFFF2, 1, 1, "R7 level accepted");
    i_clr = 1'b1; step(0, 16'h0, 0, 1, "R10 clear I");
    i_clr = 1'b0; step(1, 16'hFFF2, 1, 1, "R7 level repeats");
    irq_n = 1'b1; i_clr = 1'b1; step(0, 16'h0, 0, 1, "R10 clear I");
    i_clr = 1'b0; step(0, 16'h0, 0, 1, "R7 pin released");

    // R8: XIRQ
    xirq_n = 1'b0; step(0, 16'h0, 0, 1, "R8 held by X");
    x_clr = 1'b1; step(0, 16'h0, 0, 0, "R8 clear X");
    x_clr = 1'b0; step(1, 16'hFFF4, 1, 1, "R8 xirq sets X and I");
    step(0, 16'h0, 1, 1, "R8 masked again");
    xirq_n = 1'b1; x_clr = 1'b1; i_clr = 1'b1;
    step(0, 16'h0, 0, 0, "R8 clear both");
    x_clr = 1'b0; i_clr = 1'b0;
    xirq_n = 1'b0; flag[1] = 1'b1;
    step(1, 16'hFFF4, 1, 1, "R8 outranks maskable");
    xirq_n = 1'b1; i_clr = 1'b1; step(0, 16'h0, 0, 1, "R10 clear I");
    i_clr = 1'b0; step(1, 16'hFFEE, 1, 1, "R2 maskable after xirq");
    flag[1] = 1'b0;
    step(0, 16'h0, 1, 1, "R9 single pulse");

    @(posedge clk); #2;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule